// File: doc/BRIEF.md
# Firmware boot load sequencer

This block is a hardware master that brings up an embedded CPU inside a transceiver. After a start pulse it issues a fixed series of register accesses over a simple request port. The port carries an address, write data, read data, a held request strobe and a one-cycle completion pulse with an error flag. The block first puts the CPU control field into load mode and sets the load base address. It then prepares the indirect loader and checks the loader status. Next it streams a firmware image, taken byte by byte from a FIFO-style input, into an auto-advancing load register as 16-bit words. Finally it writes the CPU reset vector as two halves and releases the CPU.

The image length in bytes is sampled at start. Every masked update is done as a read followed by a write of `(old & ~mask) | (value & mask)`. Success leaves `done` high. Failure leaves `fail` high, with a code that says which check or which step went wrong. Both flags hold until the next accepted start.

Top module: `fw_boot_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `req_valid` and `in_ready` are low and `err_code` is 0.
- R2: A start with an odd `img_len` issues no access and consumes no byte. It sets `fail` with `err_code` 1.
- R3: The first two accesses are a read of address 0x000E and then a write to 0x000E. The write carries the read value with bits 4:0 replaced by 0b10111 and all other bits kept.
- R4: The third access writes 0x1000 to address 0x0100.
- R5: Next comes a read of 0x0101, followed by a write to 0x0101 of `(old & ~0x3FFC) | (0xC000 & 0x3FFC)`.
- R6: Next comes a read of 0x0103. A value greater than 1 stops the sequence with `fail` and `err_code` 2. In that case no load write is issued and no image byte is consumed.
- R7: The image goes out as `img_len/2` writes to 0x0102, in image order. Each word is `{byte[2k+1], byte[2k]}`, with the earlier byte in bits 7:0. A byte is consumed only in a cycle where `in_valid` and `in_ready` are both high, and a stalled input only delays the stream. A zero length skips the stream.
- R8: After the stream, 0x2000 is written to 0x0003 and then 0x0000 to 0x0004.
- R9: Last, 0x000E is read and then written with bits 4:0 replaced by 0b00001. `done` then rises with `err_code` 0.
- R10: An access that completes with `req_err` ends the sequence at once, with no further access. It sets `fail` and an `err_code` for the failing step. The codes are: control read 3, control write 4, base write 5, command read 6, command write 7, status read 8, load write 9, vector low 10, vector high 11, final control read 12, final control write 13.
- R11: `req_valid`, `req_write`, `req_addr` and `req_wdata` stay stable from the start of a request until the cycle `req_done` is seen. No FIFO byte is taken while a request is open.
- R12: A start while `busy` is ignored. `done`, `fail` and `err_code` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a boot sequence when idle |
| img_len | input | LEN_W | Image length in bytes, sampled at start |
| in_valid | input | 1 | Image byte available |
| in_data | input | BW | Image byte |
| in_ready | output | 1 | Byte taken this cycle when `in_valid` is also high |
| req_valid | output | 1 | Register request open |
| req_write | output | 1 | 1 for write, 0 for read |
| req_addr | output | AW | Register address |
| req_wdata | output | 2*BW | Write data |
| req_rdata | input | 2*BW | Read data, valid with `req_done` |
| req_done | input | 1 | Request complete (one-cycle pulse) |
| req_err | input | 1 | Request failed, valid with `req_done` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence succeeded |
| fail | output | 1 | Last sequence failed |
| err_code | output | 4 | Failure code, 0 when none |

## Verification
The bench builds the block with its default parameters: 16-bit lengths, 8-bit bytes, 16-bit addresses and the fixed boot constants. A small image then reaches every step of the sequence within a few hundred cycles. The register slave in the bench can be given a completion latency of one or more cycles and can fail any chosen access. That makes it possible to check each step's error code and the stability of a held request. A stall pattern on the byte input exercises the word packing when bytes arrive with gaps.

// File: rtl/fw_boot_seq.sv
module fw_boot_seq #(
  parameter int LEN_W = 16,
  parameter int BW = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h000E,
  parameter logic [AW-1:0] BASE_ADDR = 16'h0100,
  parameter logic [AW-1:0] CMD_ADDR = 16'h0101,
  parameter logic [AW-1:0] LOAD_ADDR = 16'h0102,
  parameter logic [AW-1:0] STS_ADDR = 16'h0103,
  parameter logic [AW-1:0] VLO_ADDR = 16'h0003,
  parameter logic [AW-1:0] VHI_ADDR = 16'h0004,
  parameter logic [2*BW-1:0] CTRL_MASK = 16'h001F,
  parameter logic [2*BW-1:0] CTRL_LOAD = 16'h0017,
  parameter logic [2*BW-1:0] CTRL_RUN = 16'h0001,
  parameter logic [2*BW-1:0] LOAD_BASE = 16'h1000,
  parameter logic [2*BW-1:0] CMD_MASK = 16'h3FFC,
  parameter logic [2*BW-1:0] CMD_VAL = 16'hC000,
  parameter logic [2*BW-1:0] STS_MAX = 16'h0001,
  parameter logic [4*BW-1:0] BOOT_VEC = 32'h0000_2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic             in_valid,
  input  logic [BW-1:0]    in_data,
  output logic             in_ready,
  output logic             req_valid,
  output logic             req_write,
  output logic [AW-1:0]    req_addr,
  output logic [2*BW-1:0]  req_wdata,
  input  logic [2*BW-1:0]  req_rdata,
  input  logic             req_done,
  input  logic             req_err,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [3:0]       err_code
);
  localparam logic [3:0] E_ODD = 4'd1;
  localparam logic [3:0] E_STS = 4'd2;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0,
    S_CRD  = 4'd3,
    S_CWR  = 4'd4,
    S_BASE = 4'd5,
    S_IRD  = 4'd6,
    S_IWR  = 4'd7,
    S_STS  = 4'd8,
    S_LOAD = 4'd9,
    S_VLO  = 4'd10,
    S_VHI  = 4'd11,
    S_RRD  = 4'd12,
    S_RWR  = 4'd13,
    S_BLO  = 4'd14,
    S_BHI  = 4'd15
  } state_t;

  state_t state, nxt;
  logic [LEN_W-1:0] words;
  logic [2*BW-1:0]  rd_q;
  logic [BW-1:0]    lo_q, hi_q;
  logic             done_q, fail_q;
  logic [3:0]       code_q;

  assign busy      = state != S_IDLE;
  assign in_ready  = state == S_BLO || state == S_BHI;
  assign req_valid = busy && !in_ready;
  assign done      = done_q;
  assign fail      = fail_q;
  assign err_code  = code_q;

  always_comb begin
    nxt       = S_IDLE;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    case (state)
      S_CRD: begin
        nxt = S_CWR;
        req_addr = CTRL_ADDR;
      end
      S_CWR: begin
        nxt = S_BASE;
        req_write = 1'b1;
        req_addr = CTRL_ADDR;
        req_wdata = (rd_q & ~CTRL_MASK) | (CTRL_LOAD & CTRL_MASK);
      end
      S_BASE: begin
        nxt = S_IRD;
        req_write = 1'b1;
        req_addr = BASE_ADDR;
        req_wdata = LOAD_BASE;
      end
      S_IRD: begin
        nxt = S_IWR;
        req_addr = CMD_ADDR;
      end
      S_IWR: begin
        nxt = S_STS;
        req_write = 1'b1;
        req_addr = CMD_ADDR;
        req_wdata = (rd_q & ~CMD_MASK) | (CMD_VAL & CMD_MASK);
      end
      S_STS: begin
        nxt = (words == '0) ? S_VLO : S_BLO;
        req_addr = STS_ADDR;
      end
      S_LOAD: begin
        nxt = (words == LEN_W'(1)) ? S_VLO : S_BLO;
        req_write = 1'b1;
        req_addr = LOAD_ADDR;
        req_wdata = {hi_q, lo_q};
      end
      S_VLO: begin
        nxt = S_VHI;
        req_write = 1'b1;
        req_addr = VLO_ADDR;
        req_wdata = BOOT_VEC[2*BW-1:0];
      end
      S_VHI: begin
        nxt = S_RRD;
        req_write = 1'b1;
        req_addr = VHI_ADDR;
        req_wdata = BOOT_VEC[4*BW-1:2*BW];
      end
      S_RRD: begin
        nxt = S_RWR;
        req_addr = CTRL_ADDR;
      end
      S_RWR: begin
        nxt = S_IDLE;
        req_write = 1'b1;
        req_addr = CTRL_ADDR;
        req_wdata = (rd_q & ~CTRL_MASK) | (CTRL_RUN & CTRL_MASK);
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      words  <= '0;
      rd_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      code_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done_q <= 1'b0;
          fail_q <= 1'b0;
          code_q <= '0;
          if (img_len[0]) begin
            fail_q <= 1'b1;
            code_q <= E_ODD;
          end else begin
            words <= img_len >> 1;
            state <= S_CRD;
          end
        end
        S_BLO: if (in_valid) begin
          lo_q  <= in_data;
          state <= S_BHI;
        end
        S_BHI: if (in_valid) begin
          hi_q  <= in_data;
          state <= S_LOAD;
        end
        default: if (req_done) begin
          if (req_err) begin
            fail_q <= 1'b1;
            code_q <= state;
            state  <= S_IDLE;
          end else if (state == S_STS && req_rdata > STS_MAX) begin
            fail_q <= 1'b1;
            code_q <= E_STS;
            state  <= S_IDLE;
          end else begin
            rd_q  <= req_rdata;
            state <= nxt;
            if (state == S_LOAD) words <= words - LEN_W'(1);
            if (state == S_RWR) done_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fw_boot_seq_chk.sv
module fw_boot_seq_chk #(
  parameter int LEN_W = 16,
  parameter int BW = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h000E,
  parameter logic [2*BW-1:0] CTRL_MASK = 16'h001F,
  parameter logic [2*BW-1:0] CTRL_LOAD = 16'h0017,
  parameter logic [2*BW-1:0] CTRL_RUN = 16'h0001
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] img_len,
  input logic             in_ready,
  input logic             req_valid,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic [2*BW-1:0]  req_wdata,
  input logic             req_done,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic [3:0]       err_code
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_done |=> req_valid && $stable(req_write) && $stable(req_addr) && $stable(req_wdata));

  // R11
  no_pop_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !req_valid);

  // R2
  odd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && img_len[0] |=> !req_valid && fail && err_code == 4'd1);

  // R3
  ctrl_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_addr == CTRL_ADDR |->
      ((req_wdata & CTRL_MASK) == (CTRL_LOAD & CTRL_MASK)) || ((req_wdata & CTRL_MASK) == (CTRL_RUN & CTRL_MASK)));

  // R12
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> err_code != 4'd0 && !done);

  // R9
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> err_code == 4'd0 && !busy);
endmodule

bind fw_boot_seq fw_boot_seq_chk #(
  .LEN_W(LEN_W), .BW(BW), .AW(AW), .CTRL_ADDR(CTRL_ADDR),
  .CTRL_MASK(CTRL_MASK), .CTRL_LOAD(CTRL_LOAD), .CTRL_RUN(CTRL_RUN)
) u_chk (.*);

// File: tb/sim_fw_boot_seq.sv
module sim_fw_boot_seq;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] img_len = '0;
  logic in_valid, in_ready;
  logic [7:0] in_data;
  logic req_valid, req_write, req_done, req_err;
  logic [15:0] req_addr, req_wdata, req_rdata;
  logic busy, done, fail;
  logic [3:0] err_code;

  always #(PERIOD/2) clk = ~clk;

  fw_boot_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_rdata(req_rdata), .req_done(req_done),
    .req_err(req_err), .busy(busy), .done(done), .fail(fail), .err_code(err_code)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // image source
  logic [7:0] img [64];
  int nbytes = 0, ptr = 0;
  bit stall_en = 0, stall_ph = 0;
  assign in_valid = (ptr < nbytes) && !(stall_en && stall_ph);
  assign in_data  = img[ptr % 64];
  always @(posedge clk) begin
    stall_ph <= ~stall_ph;
    if (in_valid && in_ready) ptr <= ptr + 1;
  end

  // register slave
  logic [15:0] r_ctrl, r_cmd, r_sts;
  int lat = 0, cnt = 0, inj = 0, nacc = 0;
  bit lw [64];
  logic [15:0] la [64];
  logic [15:0] ld [64];
  always @(posedge clk) begin
    req_done <= 1'b0;
    req_err  <= 1'b0;
    if (req_valid && !req_done) begin
      if (cnt < lat) cnt <= cnt + 1;
      else begin
        cnt <= 0;
        req_done <= 1'b1;
        lw[nacc % 64] <= req_write;
        la[nacc % 64] <= req_addr;
        ld[nacc % 64] <= req_write ? req_wdata : 16'h0;
        nacc <= nacc + 1;
        if (nacc + 1 == inj) req_err <= 1'b1;
        else if (req_write) begin
          if (req_addr == 16'h000E) r_ctrl <= req_wdata;
          if (req_addr == 16'h0101) r_cmd <= req_wdata;
        end else begin
          case (req_addr)
            16'h000E: req_rdata <= r_ctrl;
            16'h0101: req_rdata <= r_cmd;
            16'h0103: req_rdata <= r_sts;
            default:  req_rdata <= 16'h0;
          endcase
        end
      end
    end
  end

  // expected access list
  bit ew [64];
  logic [15:0] ea [64];
  logic [15:0] ed [64];
  int nexp = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic add(bit w, logic [15:0] a, logic [15:0] d);
    ew[nexp] = w; ea[nexp] = a; ed[nexp] = d; nexp++;
  endtask

  function automatic logic [15:0] rmw(logic [15:0] o, logic [15:0] m, logic [15:0] v);
    return (o & ~m) | (v & m);
  endfunction

  task automatic setup(logic [15:0] c, logic [15:0] m, logic [15:0] s, int l, int j, int n, bit st);
    @(negedge clk);
    r_ctrl = c; r_cmd = m; r_sts = s; lat = l; inj = j;
    nbytes = n; ptr = 0; nacc = 0; nexp = 0; stall_en = st;
    for (int i = 0; i < n; i++) img[i] = 8'(8'h11 * (i + 1) + 8'h3C * (l % 2));
  endtask

  task automatic run(int len, bit dup_start);
    img_len = 16'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dup_start) begin
      repeat (5) @(negedge clk);
      img_len = 16'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cmp_seq(string req);
    chk({req, " access count"}, nacc, nexp);
    for (int i = 0; i < nexp && i < nacc; i++) begin
      chk({req, " write flag"}, lw[i], ew[i]);
      chk({req, " address"}, la[i], ea[i]);
      if (ew[i]) chk({req, " write data"}, ld[i], ed[i]);
    end
  endtask

  task automatic add_full(logic [15:0] c, logic [15:0] m, int n);
    logic [15:0] cw;
    cw = rmw(c, 16'h001F, 16'h0017);
    add(0, 16'h000E, 0); add(1, 16'h000E, cw);
    add(1, 16'h0100, 16'h1000);
    add(0, 16'h0101, 0); add(1, 16'h0101, rmw(m, 16'h3FFC, 16'hC000));
    add(0, 16'h0103, 0);
    for (int k = 0; k < n / 2; k++) add(1, 16'h0102, {img[2*k+1], img[2*k]});
    add(1, 16'h0003, 16'h2000); add(1, 16'h0004, 16'h0000);
    add(0, 16'h000E, 0); add(1, 16'h000E, rmw(cw, 16'h001F, 16'h0001));
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 fail", fail, 0);
    chk("R1 req_valid", req_valid, 0); chk("R1 in_ready", in_ready, 0); chk("R1 err_code", err_code, 0);
  endtask

  task automatic t_normal();
    setup(16'hFFE8, 16'hFFFF, 16'h0001, 0, 0, 6, 0);
    add_full(16'hFFE8, 16'hFFFF, 6);
    run(6, 1);
    cmp_seq("R3 R4 R5 R7 R8 R9 R12 normal");
    chk("R9 done", done, 1); chk("R9 code", err_code, 0);
    chk("R7 bytes taken", ptr, 6);
    repeat (5) @(negedge clk);
    chk("R12 done held", done, 1);
  endtask

  task automatic t_stall();
    setup(16'h0000, 16'h8001, 16'h0000, 3, 0, 4, 1);
    add_full(16'h0000, 16'h8001, 4);
    run(4, 0);
    cmp_seq("R7 stalled input");
    chk("R9 done stalled", done, 1);
  endtask

  task automatic t_zero();
    setup(16'h1234, 16'h0000, 16'h0001, 1, 0, 4, 0);
    add_full(16'h1234, 16'h0000, 0);
    run(0, 0);
    cmp_seq("R7 zero length");
    chk("R7 zero length bytes", ptr, 0);
    chk("R9 zero length done", done, 1);
  endtask

  task automatic t_status(logic [15:0] s);
    setup(16'h0000, 16'h0000, s, 0, 0, 6, 0);
    run(6, 0);
    chk("R6 access count", nacc, 6);
    chk("R6 bytes", ptr, 0);
    chk("R6 fail", fail, 1); chk("R6 code", err_code, 2);
    chk("R6 done", done, 0);
  endtask

  task automatic t_odd();
    setup(16'h0000, 16'h0000, 16'h0000, 0, 0, 6, 0);
    run(5, 0);
    chk("R2 access count", nacc, 0);
    chk("R2 bytes", ptr, 0);
    chk("R2 fail", fail, 1); chk("R2 code", err_code, 1);
  endtask

  task automatic t_err(int at, logic [3:0] code, int bytes);
    setup(16'h0000, 16'h0000, 16'h0000, 1, at, 6, 0);
    run(6, 0);
    repeat (10) @(negedge clk);
    chk("R10 access count", nacc, at);
    chk("R10 code", err_code, code);
    chk("R10 fail", fail, 1);
    chk("R10 bytes", ptr, bytes);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_stall();
    t_zero();
    t_status(16'h0002);
    t_status(16'h8000);
    t_odd();
    t_err(1, 4'd3, 0);
    t_err(5, 4'd7, 0);
    t_err(7, 4'd9, 2);
    t_err(13, 4'd13, 6);
    t_normal();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule